// File: doc/BRIEF.md
# Persistent Request Ordering Arbiter

This block orders starvation-avoidance requests for a range of block addresses. Each processor has a miss timer. When a processor's ordinary coherence request is issued, the timer starts. If the request is still unsatisfied after a fixed number of cycles, about one average memory latency, the timer raises a persistent request carrying the processor number and the block address. The processor does not retry first. Pending persistent requests pass through a valid/ready stage into a first-in first-out queue. At most one queued request is granted at any time, and the grant is announced by an activate broadcast.

The granted processor ends its turn by sending a deactivate to the arbiter. On the next edge the arbiter broadcasts that deactivate. One cycle later it broadcasts the activate for the next queued request. A handoff therefore takes three message slots: the deactivate in, the deactivate out, and the next activate. A queued request is never discarded. If a processor produces a second persistent request while its first is still queued or granted, the second is refused and the refusal is reported on an error pulse.

Back-pressure follows one rule. A timer's pending request is held, not lost, for as long as the queue is full. It is consumed only in a cycle where the selection stage accepts it into the queue or refuses it as a duplicate. The broadcast outputs are single-cycle pulses, and the network must absorb them.

Top module: `persist_arbiter`

## Requirements
- R1: A persistent request is raised exactly MISS_TIMEOUT cycles after a miss start, if no hit arrives in between. With an idle queue, the activate for it is visible MISS_TIMEOUT+2 edges after the edge that sampled the start.
- R2: A hit on a processor before its timer expires cancels the request, and no activate for it is ever broadcast.
- R3: At most one processor is granted at a time. No activate is broadcast between an activate and the matching deactivate broadcast.
- R4: A deactivate from the granted processor produces a deactivate broadcast on the next edge, with that processor's number and address. If a request is queued, the next activate follows exactly one cycle later, and the two never coincide.
- R5: A deactivate carrying a processor number other than the granted one, or arriving while nothing is granted, is ignored and produces no broadcast.
- R6: Requests are granted in the order they entered the queue. When several timers expire in the same cycle, they enter one per cycle, lowest processor number first.
- R7: A request that enters the queue on the same edge that samples a deactivate is eligible for the activate that immediately follows that deactivate.
- R8: A request from a processor that is already queued or granted is refused. The refusal is a one-cycle pulse on dup_err, with the processor number on dup_id. The refused request is never activated.
- R9: q_full is high while QDEPTH entries are held. While it is high, no entry is added and pending requests wait. No accepted request is ever dropped.
- R10: After reset, act_v, deact_v, dup_err and q_full are low, and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_start | input | NPROC | Per-processor pulse: transient request issued, timer starts |
| miss_addr | input | NPROC*AW | Per-processor block address, captured with miss_start |
| miss_hit | input | NPROC | Per-processor pulse: transient request satisfied, timer cancelled |
| deact_in_v | input | 1 | Deactivate received from a processor |
| deact_in_id | input | IW | Processor number of the received deactivate |
| act_v | output | 1 | Activate broadcast pulse |
| act_id | output | IW | Processor granted by the activate |
| act_addr | output | AW | Block address of the activate |
| deact_v | output | 1 | Deactivate broadcast pulse |
| deact_id | output | IW | Processor released by the deactivate |
| deact_addr | output | AW | Block address released |
| q_full | output | 1 | Queue holds QDEPTH entries |
| dup_err | output | 1 | Duplicate persistent request refused (pulse) |
| dup_id | output | IW | Processor whose duplicate was refused |

## Verification
The hardest case to reach is a queue entry that lands on the very edge where the granted processor's deactivate is sampled. The timer expiry and the deactivate must line up to the cycle, or the test only shows ordinary FIFO behaviour. The stimulus starts a miss at a cycle it records. It then counts exactly MISS_TIMEOUT cycles before driving the deactivate, so that the timer's request enters the queue on the same edge the deactivate is sampled. The duplicate refusal is reached in a similar way: a second miss is started on a processor while that processor still holds the grant.

// File: rtl/parb_pkg.sv
package parb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_GAP  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/parb_miss_timer.sv
module parb_miss_timer #(
  parameter int AW      = 16,
  parameter int TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  input  logic          hit,
  input  logic          take,
  output logic          pend,
  output logic [AW-1:0] addr_out
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pend     <= 1'b0;
      cnt      <= '0;
      addr_out <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      pend     <= 1'b0;
      cnt      <= CW'(TIMEOUT);
      addr_out <= addr_in;
    end else if (hit) begin
      busy <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (take) pend <= 1'b0;
      if (busy) begin
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          pend <= 1'b1;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/parb_req_pick.sv
module parb_req_pick #(
  parameter int NPROC = 4,
  parameter int IW    = 2
) (
  input  logic [NPROC-1:0] pend,
  input  logic [NPROC-1:0] inq,
  input  logic             full,
  output logic             enq_v,
  output logic             dup_v,
  output logic [IW-1:0]    sel_id,
  output logic [NPROC-1:0] take
);
  logic found;

  always_comb begin
    found  = 1'b0;
    sel_id = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found  = 1'b1;
        sel_id = IW'(i);
      end
    end
    dup_v = found && inq[sel_id];
    enq_v = found && !inq[sel_id] && !full;
    take  = '0;
    if (enq_v || dup_v) take[sel_id] = 1'b1;
  end
endmodule

// File: rtl/parb_fifo.sv
module parb_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_v,
  input  logic [W-1:0]                     wr_data,
  input  logic                             rd_v,
  output logic [W-1:0]                     head,
  output logic [$clog2(DEPTH + 1)-1:0]     count,
  output logic                             full,
  output logic                             empty
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_wr, do_rd;

  assign full  = (count == CNTW'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = wr_v && !full;
  assign do_rd = rd_v && !empty;
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (do_rd) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      case ({do_wr, do_rd})
        2'b10:   count <= count + CNTW'(1);
        2'b01:   count <= count - CNTW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/persist_arbiter.sv
module persist_arbiter #(
  parameter int NPROC        = 4,
  parameter int AW           = 16,
  parameter int MISS_TIMEOUT = 16,
  parameter int QDEPTH       = NPROC,
  parameter int IW           = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPROC-1:0]   miss_start,
  input  logic [NPROC*AW-1:0] miss_addr,
  input  logic [NPROC-1:0]   miss_hit,
  input  logic               deact_in_v,
  input  logic [IW-1:0]      deact_in_id,
  output logic               act_v,
  output logic [IW-1:0]      act_id,
  output logic [AW-1:0]      act_addr,
  output logic               deact_v,
  output logic [IW-1:0]      deact_id,
  output logic [AW-1:0]      deact_addr,
  output logic               q_full,
  output logic               dup_err,
  output logic [IW-1:0]      dup_id
);
  import parb_pkg::*;

  localparam int EW  = IW + AW;
  localparam int QCW = $clog2(QDEPTH + 1);

  logic [NPROC-1:0]    pend, take, inq;
  logic [NPROC*AW-1:0] paddr;
  logic                enq_v, dup_v, q_empty, pop;
  logic [IW-1:0]       sel_id, head_id;
  logic [AW-1:0]       head_addr;
  logic [EW-1:0]       head;
  logic [QCW-1:0]      q_cnt;
  arb_state_e          state;

  for (genvar g = 0; g < NPROC; g++) begin : g_tmr
    parb_miss_timer #(.AW(AW), .TIMEOUT(MISS_TIMEOUT)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (miss_start[g]),
      .addr_in  (miss_addr[g*AW +: AW]),
      .hit      (miss_hit[g]),
      .take     (take[g]),
      .pend     (pend[g]),
      .addr_out (paddr[g*AW +: AW])
    );
  end

  parb_req_pick #(.NPROC(NPROC), .IW(IW)) u_pick (
    .pend   (pend),
    .inq    (inq),
    .full   (q_full),
    .enq_v  (enq_v),
    .dup_v  (dup_v),
    .sel_id (sel_id),
    .take   (take)
  );

  parb_fifo #(.W(EW), .DEPTH(QDEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_v    (enq_v),
    .wr_data ({sel_id, paddr[sel_id*AW +: AW]}),
    .rd_v    (pop),
    .head    (head),
    .count   (q_cnt),
    .full    (q_full),
    .empty   (q_empty)
  );

  assign head_id   = head[EW-1 -: IW];
  assign head_addr = head[AW-1:0];
  assign pop       = (state == ST_HOLD) && deact_in_v && (deact_in_id == head_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inq <= '0;
    end else begin
      for (int i = 0; i < NPROC; i++) begin
        if (enq_v && sel_id == IW'(i)) inq[i] <= 1'b1;
        else if (pop && head_id == IW'(i)) inq[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      act_v      <= 1'b0;
      act_id     <= '0;
      act_addr   <= '0;
      deact_v    <= 1'b0;
      deact_id   <= '0;
      deact_addr <= '0;
      dup_err    <= 1'b0;
      dup_id     <= '0;
    end else begin
      act_v   <= 1'b0;
      deact_v <= 1'b0;
      dup_err <= dup_v;
      if (dup_v) dup_id <= sel_id;
      case (state)
        ST_IDLE, ST_GAP: begin
          if (!q_empty) begin
            act_v    <= 1'b1;
            act_id   <= head_id;
            act_addr <= head_addr;
            state    <= ST_HOLD;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (pop) begin
            deact_v    <= 1'b1;
            deact_id   <= head_id;
            deact_addr <= head_addr;
            state      <= ST_GAP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/parb_check.sv
module parb_check #(
  parameter int IW  = 2,
  parameter int QCW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           act_v,
  input logic           deact_v,
  input logic           deact_in_v,
  input logic [IW-1:0]  deact_in_id,
  input logic [IW-1:0]  deact_id,
  input logic           q_full,
  input logic [QCW-1:0] q_cnt
);
  logic owned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owned <= 1'b0;
    else if (act_v) owned <= 1'b1;
    else if (deact_v) owned <= 1'b0;
  end

  assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_v |-> !owned);

  assert_act_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_v |=> !act_v);

  assert_deact_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    deact_v |-> ($past(deact_in_v) && $past(deact_in_id) == deact_id));

  assert_no_collide_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_v && deact_v));

  assert_deact_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    deact_v |-> owned);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |=> (q_cnt <= $past(q_cnt)));
endmodule

bind persist_arbiter parb_check #(.IW(IW), .QCW(QCW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .act_v       (act_v),
  .deact_v     (deact_v),
  .deact_in_v  (deact_in_v),
  .deact_in_id (deact_in_id),
  .deact_id    (deact_id),
  .q_full      (q_full),
  .q_cnt       (q_cnt)
);

// File: tb/sim_persist_arbiter.sv
module sim_persist_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 4;
  localparam int AW  = 16;
  localparam int TMO = 16;
  localparam int IW  = 2;
  localparam int NVEC = 4;
  localparam logic [NP-1:0] VEC_MASK [NVEC] = '{4'b0101, 4'b1110, 4'b1000, 4'b1111};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    miss_start = '0;
  logic [NP*AW-1:0] miss_addr = '0;
  logic [NP-1:0]    miss_hit = '0;
  logic             deact_in_v = 1'b0;
  logic [IW-1:0]    deact_in_id = '0;
  logic act_v, deact_v, q_full, dup_err;
  logic [IW-1:0] act_id, deact_id, dup_id;
  logic [AW-1:0] act_addr, deact_addr;

  int cyc = 0, checks = 0, fails = 0, s_cyc = 0, d_cyc = 0;
  bit done = 1'b0;

  persist_arbiter #(.NPROC(NP), .AW(AW), .MISS_TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .miss_start(miss_start), .miss_addr(miss_addr),
    .miss_hit(miss_hit), .deact_in_v(deact_in_v), .deact_in_id(deact_in_id),
    .act_v(act_v), .act_id(act_id), .act_addr(act_addr), .deact_v(deact_v),
    .deact_id(deact_id), .deact_addr(deact_addr), .q_full(q_full),
    .dup_err(dup_err), .dup_id(dup_id)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int addr_of(int p, int v);
    return 'hA000 + v * 16 + p;
  endfunction

  task automatic chk(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic start_miss(logic [NP-1:0] mask, int v);
    @(negedge clk);
    for (int p = 0; p < NP; p++) miss_addr[p*AW +: AW] = AW'(addr_of(p, v));
    miss_start = mask;
    s_cyc = cyc + 1;
    @(negedge clk);
    miss_start = '0;
  endtask

  task automatic send_deact(int id);
    @(negedge clk);
    deact_in_v = 1'b1;
    deact_in_id = IW'(id);
    d_cyc = cyc + 1;
    @(negedge clk);
    deact_in_v = 1'b0;
  endtask

  task automatic wait_act(output int id, output int addr, output int stamp);
    id = -1; addr = -1; stamp = -1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (act_v) begin
        id = int'(act_id); addr = int'(act_addr); stamp = cyc;
        return;
      end
    end
  endtask

  task automatic count_acts(int n, output int acts, output int deacts);
    acts = 0; deacts = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (act_v) acts++;
      if (deact_v) deacts++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int id, addr, st, na, nd, first, dup_seen, dup_who;
    repeat (3) @(negedge clk);
    chk("R10 act_v in reset", int'(act_v), 0);
    chk("R10 deact_v in reset", int'(deact_v), 0);
    chk("R10 q_full in reset", int'(q_full), 0);
    chk("R10 dup_err in reset", int'(dup_err), 0);
    rst_n = 1'b1;
    count_acts(5, na, nd);
    chk("R10 no activity after reset", na + nd, 0);

    // Table walk: simultaneous expiries, ascending order, timing of handoff
    for (int v = 0; v < NVEC; v++) begin
      start_miss(VEC_MASK[v], v);
      first = 1;
      for (int p = 0; p < NP; p++) begin
        if (VEC_MASK[v][p]) begin
          wait_act(id, addr, st);
          chk("R6 activate order id", id, p);
          chk("R6 activate address", addr, addr_of(p, v));
          if (first != 0) chk("R1 first activate latency", st - s_cyc, TMO + 2);
          else            chk("R4 activate one cycle after deactivate", st - d_cyc, 1);
          if (VEC_MASK[v] == 4'b1111 && p == 0) begin
            repeat (4) @(negedge clk);
            chk("R9 q_full with all entries held", int'(q_full), 1);
          end
          first = 0;
          send_deact(p);
          chk("R4 deactivate broadcast", int'(deact_v), 1);
          chk("R4 deactivate id", int'(deact_id), p);
          chk("R4 deactivate address", int'(deact_addr), addr_of(p, v));
        end
      end
      count_acts(10, na, nd);
      chk("R3 no activate once queue drained", na, 0);
    end

    // R2: hit before timeout cancels
    start_miss(4'b0100, 9);
    repeat (4) @(negedge clk);
    miss_hit = 4'b0100;
    @(negedge clk);
    miss_hit = '0;
    count_acts(40, na, nd);
    chk("R2 cancelled miss gives no activate", na, 0);

    // R6: arrival order beats processor number
    start_miss(4'b1000, 5);
    repeat (3) @(negedge clk);
    start_miss(4'b0001, 6);
    wait_act(id, addr, st);
    chk("R6 earlier arrival granted first", id, 3);
    send_deact(3);
    wait_act(id, addr, st);
    chk("R6 later arrival granted second", id, 0);
    send_deact(0);
    chk("R6 deactivate of second", int'(deact_id), 0);

    // R5: wrong-id deactivate ignored; R7: same-edge enqueue and deactivate
    start_miss(4'b0001, 7);
    wait_act(id, addr, st);
    chk("R5 setup grant", id, 0);
    send_deact(1);
    chk("R5 foreign deactivate ignored", int'(deact_v), 0);
    count_acts(5, na, nd);
    chk("R5 no broadcast after foreign deactivate", na + nd, 0);
    start_miss(4'b0100, 8);
    repeat (TMO - 1) @(negedge clk);
    send_deact(0);
    chk("R7 deactivate broadcast cycle", d_cyc - s_cyc, TMO + 1);
    chk("R7 deactivate visible", int'(deact_v), 1);
    @(negedge clk);
    chk("R7 activate right after deactivate", int'(act_v), 1);
    chk("R7 activate id", int'(act_id), 2);
    send_deact(2);
    chk("R7 release", int'(deact_id), 2);

    // R8: duplicate while granted
    start_miss(4'b0010, 11);
    wait_act(id, addr, st);
    chk("R8 setup grant", id, 1);
    start_miss(4'b0010, 12);
    dup_seen = 0; dup_who = -1; na = 0;
    for (int k = 0; k < TMO + 6; k++) begin
      @(negedge clk);
      if (dup_err) begin dup_seen++; dup_who = int'(dup_id); end
      if (act_v) na++;
    end
    chk("R8 duplicate refused once", dup_seen, 1);
    chk("R8 duplicate id", dup_who, 1);
    chk("R8 no activate during duplicate", na, 0);
    send_deact(1);
    chk("R8 original released", int'(deact_v), 1);
    count_acts(30, na, nd);
    chk("R8 refused request never activated", na, 0);

    finish_run();
  end
endmodule